// File: doc/BRIEF.md
# Bidirectional GPIO Port Controller

An eight-pin general-purpose I/O port controlled through a small register bus. Software writes a direction register and a data register. It reads the pad levels back through a pin-input location, and that location accepts no writes. Separate set-bit and clear-bit strobes change one bit of the data or direction register without a read-modify-write, so one pin can be changed without disturbing its neighbours.

On a pin whose direction bit marks it as an input, the data bit does not drive the pad. It selects the pull-up instead. A port-wide pull-up-kill input turns every pull-up off at once. Any pin can be claimed by a peripheral through an override. The override then supplies that pin's output enable and output value, and its pull-up is held off. Every other pin keeps working from the registers. The pad levels are synchronised by two flops before they can be read back.

Top module: `gpio_port`

## Requirements
- R1: While `rst_n` is low and after it is released, both the data and direction registers are zero. With no override active, `pad_oe` and `pad_pu` are then zero.
- R2: Register codes are 0 for data, 1 for direction, 2 for pin input and 3 unused. A full write (`bus_wr`) to code 0 or 1 loads `bus_wdata`. A read strobe (`bus_rd`) loads `bus_rdata` at the next edge with the addressed value. Code 3 reads as zero. `bus_rdata` holds its value while `bus_rd` is low.
- R3: Full writes, set strobes and clear strobes aimed at code 2 or code 3 leave the data and direction registers unchanged.
- R4: `bus_bset` aimed at code 0 or 1 sets bit `bus_bidx` of that register. No other bit changes.
- R5: `bus_bclr` aimed at code 0 or 1 clears bit `bus_bidx` of that register. No other bit changes.
- R6: When several operations arrive in the same cycle, `bus_wr` takes priority over `bus_bset`, and `bus_bset` takes priority over `bus_bclr`.
- R7: For a pin with no override, `pad_oe` equals its direction bit (1 means output) and `pad_out` equals its data bit.
- R8: For a pin with no override, `pad_pu` is high exactly when its direction bit is 0, its data bit is 1 and `pu_kill` is low. `pad_pu` is never high on a pin whose `pad_oe` is high.
- R9: While `pu_kill` is high, every bit of `pad_pu` is zero.
- R10: A pad level sampled at clock edge k is returned by a pin-input read captured at edge k+2 or later. A read captured at edge k+1 still returns the older level.
- R11: When `alt_en[n]` is high, `pad_oe[n]` follows `alt_oe[n]`, `pad_out[n]` follows `alt_out[n]` and `pad_pu[n]` is zero. Pins whose `alt_en` bit is low are not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register code |
| bus_wr | input | 1 | Full write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | WIDTH (8) | Write data |
| bus_bset | input | 1 | Single-bit set strobe |
| bus_bclr | input | 1 | Single-bit clear strobe |
| bus_bidx | input | IDX_W (3) | Bit index for set and clear |
| bus_rdata | output | WIDTH (8) | Registered read data |
| pu_kill | input | 1 | Port-wide pull-up disable |
| alt_en | input | WIDTH (8) | Per-pin peripheral override enable |
| alt_oe | input | WIDTH (8) | Override output enable |
| alt_out | input | WIDTH (8) | Override output value |
| pad_in | input | WIDTH (8) | Asynchronous pad levels |
| pad_oe | output | WIDTH (8) | Per-pin output enable |
| pad_out | output | WIDTH (8) | Per-pin output value |
| pad_pu | output | WIDTH (8) | Per-pin pull-up enable |

## Verification
The pad outputs are combinational from the registers. A wrong bit in the data or direction register therefore shows on `pad_oe`, `pad_out` or `pad_pu` in the same cycle as the faulty update, and a read one edge later shows it too. A set or clear strobe that touches a neighbouring bit, or a write to the read-only location that leaks into the registers, appears as an unexpected readback right after the operation. A synchroniser with the wrong depth shifts the cycle in which a new pad level is first read back by one, and back-to-back reads around the pad change expose that shift.

// File: rtl/gpio_port_pkg.sv
// Package: shared register codes for the GPIO port.
// Assumes: a 2-bit register code on the bus.
package gpio_port_pkg;
    typedef enum logic [1:0] {
        RSEL_DATA = 2'd0,
        RSEL_DIR  = 2'd1,
        RSEL_PIN  = 2'd2,
        RSEL_NONE = 2'd3
    } reg_sel_e;

    localparam int unsigned NUM_RW_REGS = 2;
endpackage

// File: rtl/gpio_ctl_regs.sv
// Module: the data and direction registers, with full write plus
// single-bit set and clear. Priority is write, then set, then clear.
// Assumes: register codes from gpio_port_pkg; synchronous active-low reset.
module gpio_ctl_regs
    import gpio_port_pkg::*;
#(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned IDX_W = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       addr,
    input  logic             wr,
    input  logic [WIDTH-1:0] wdata,
    input  logic             bset,
    input  logic             bclr,
    input  logic [IDX_W-1:0] bidx,
    output logic [WIDTH-1:0] data_q,
    output logic [WIDTH-1:0] dir_q
);
    logic [WIDTH-1:0] bit_mask;
    logic [WIDTH-1:0] reg_q [NUM_RW_REGS];

    // Decode the bit index into a one-hot mask.
    always_comb bit_mask = WIDTH'(1) << bidx;

    for (genvar g = 0; g < NUM_RW_REGS; g++) begin : g_reg
        logic             hit;
        logic [WIDTH-1:0] nxt;

        // Match the bus code against this register's slot.
        always_comb hit = (addr == 2'(g));

        // Select the next value by operation priority.
        always_comb begin
            nxt = reg_q[g];
            if (hit) begin
                if (wr)        nxt = wdata;
                else if (bset) nxt = reg_q[g] | bit_mask;
                else if (bclr) nxt = reg_q[g] & ~bit_mask;
            end
        end

        // Hold the register; clear it on reset.
        always_ff @(posedge clk) begin
            if (!rst_n) reg_q[g] <= '0;
            else        reg_q[g] <= nxt;
        end

        AST_BITOP_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
            (!wr && (bset || bclr)) |=> ($countones(reg_q[g] ^ $past(reg_q[g])) <= 1)); // R4
    end

    assign data_q = reg_q[RSEL_DATA];
    assign dir_q  = reg_q[RSEL_DIR];

    AST_PIN_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (addr[1] && (wr || bset || bclr)) |=> ($stable(data_q) && $stable(dir_q))); // R3
endmodule

// File: rtl/gpio_in_sync.sv
// Module: a multi-flop synchroniser for asynchronous pad levels, one chain per pin.
// Assumes: STAGES >= 2; the pads are sampled bit by bit with no bus coherence.
module gpio_in_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        // Shift the pad level one stage down the chain.
        always_ff @(posedge clk) begin
            if (!rst_n)      stage_q[s] <= '0;
            else if (s == 0) stage_q[s] <= async_in;
            else             stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
        end
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_pad_mux.sv
// Module: per-pin pad control, choosing between the registers and a
// peripheral override. Also derives the pull-up enable.
// Assumes: purely combinational; the clock is used only by the checks.
module gpio_pad_mux #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] dir_q,
    input  logic [WIDTH-1:0] data_q,
    input  logic             pu_kill,
    input  logic [WIDTH-1:0] alt_en,
    input  logic [WIDTH-1:0] alt_oe,
    input  logic [WIDTH-1:0] alt_out,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_pu
);
    for (genvar n = 0; n < WIDTH; n++) begin : g_pin
        // Pick the owner of the pad driver for this pin.
        always_comb begin
            if (alt_en[n]) begin
                pad_oe[n]  = alt_oe[n];
                pad_out[n] = alt_out[n];
            end else begin
                pad_oe[n]  = dir_q[n];
                pad_out[n] = data_q[n];
            end
        end

        // Pull-up only on a register-owned input pin whose data bit is set.
        always_comb pad_pu[n] = !alt_en[n] && !dir_q[n] && data_q[n] && !pu_kill;
    end

    AST_PU_NOT_WITH_OE: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_pu & pad_oe) == '0)); // R8
    AST_PU_KILL_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        pu_kill |-> (pad_pu == '0)); // R9
    AST_ALT_NO_PU: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_pu & alt_en) == '0)); // R11
endmodule

// File: rtl/gpio_port.sv
// Module: top of the GPIO port. It joins the register bank, the input
// synchroniser and the pad multiplexer, and registers the read data.
// Assumes: one bus operation per cycle from a simple master; read data is
// valid one edge after bus_rd.
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int unsigned WIDTH       = 8,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned IDX_W       = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       bus_addr,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [WIDTH-1:0] bus_wdata,
    input  logic             bus_bset,
    input  logic             bus_bclr,
    input  logic [IDX_W-1:0] bus_bidx,
    output logic [WIDTH-1:0] bus_rdata,
    input  logic             pu_kill,
    input  logic [WIDTH-1:0] alt_en,
    input  logic [WIDTH-1:0] alt_oe,
    input  logic [WIDTH-1:0] alt_out,
    input  logic [WIDTH-1:0] pad_in,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_pu
);
    logic [WIDTH-1:0] data_q;
    logic [WIDTH-1:0] dir_q;
    logic [WIDTH-1:0] pin_sync;
    logic [WIDTH-1:0] rd_mux;

    gpio_ctl_regs #(.WIDTH(WIDTH), .IDX_W(IDX_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr), .wdata(bus_wdata),
        .bset(bus_bset), .bclr(bus_bclr), .bidx(bus_bidx),
        .data_q(data_q), .dir_q(dir_q)
    );

    gpio_in_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(pad_in), .sync_out(pin_sync)
    );

    gpio_pad_mux #(.WIDTH(WIDTH)) u_mux (
        .clk(clk), .rst_n(rst_n), .dir_q(dir_q), .data_q(data_q), .pu_kill(pu_kill),
        .alt_en(alt_en), .alt_oe(alt_oe), .alt_out(alt_out),
        .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
    );

    // Select the readback source from the register code.
    always_comb begin
        unique case (reg_sel_e'(bus_addr))
            RSEL_DATA: rd_mux = data_q;
            RSEL_DIR:  rd_mux = dir_q;
            RSEL_PIN:  rd_mux = pin_sync;
            default:   rd_mux = '0;
        endcase
    end

    // Capture read data on a read strobe; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata)); // R2
    AST_UNUSED_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 2'd3) |=> (bus_rdata == '0)); // R2
endmodule

// File: tb/sim_gpio_port.sv
// Bench: scoreboard. The driver pushes the expected read values into a queue,
// and a monitor pops and compares them one edge after each read.
module sim_gpio_port;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   bus_addr = '0;
    logic         bus_wr = 1'b0, bus_rd = 1'b0, bus_bset = 1'b0, bus_bclr = 1'b0;
    logic [W-1:0] bus_wdata = '0;
    logic [2:0]   bus_bidx = '0;
    logic [W-1:0] bus_rdata;
    logic         pu_kill = 1'b0;
    logic [W-1:0] alt_en = '0, alt_oe = '0, alt_out = '0, pad_in = '0;
    logic [W-1:0] pad_oe, pad_out, pad_pu;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [W-1:0] exp_q[$];
    string tag_q[$];
    logic rd_seen = 1'b0;

    always #2.5 clk = ~clk;

    gpio_port u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_bset(bus_bset), .bus_bclr(bus_bclr), .bus_bidx(bus_bidx),
        .bus_rdata(bus_rdata), .pu_kill(pu_kill), .alt_en(alt_en), .alt_oe(alt_oe),
        .alt_out(alt_out), .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
    );

    task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: note which edges captured a read, then compare at the next negedge.
    always @(posedge clk) rd_seen <= bus_rd;
    always @(negedge clk) begin
        if (rd_seen && exp_q.size() > 0) begin
            check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
        end
    end

    task automatic idle();
        @(negedge clk);
        bus_wr = 0; bus_rd = 0; bus_bset = 0; bus_bclr = 0;
    endtask

    task automatic wr_reg(logic [1:0] a, logic [W-1:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
        idle();
    endtask

    task automatic bit_op(logic [1:0] a, logic [2:0] idx, bit set, bit clr);
        @(negedge clk); bus_addr = a; bus_bidx = idx; bus_bset = set; bus_bclr = clr;
        idle();
    endtask

    task automatic rd_reg(logic [1:0] a, logic [W-1:0] exp, string tag);
        @(negedge clk); bus_addr = a; bus_rd = 1;
        exp_q.push_back(exp); tag_q.push_back(tag);
        idle();
    endtask

    task automatic check_pads(logic [W-1:0] e_oe, logic [W-1:0] e_out, logic [W-1:0] e_pu, string tag);
        #1;
        check({tag, " pad_oe"}, pad_oe, e_oe);
        check({tag, " pad_out"}, pad_out, e_out);
        check({tag, " pad_pu"}, pad_pu, e_pu);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check_pads(8'h00, 8'h00, 8'h00, "R1 in reset");
        @(negedge clk); rst_n = 1;
        check_pads(8'h00, 8'h00, 8'h00, "R1 after reset");
        rd_reg(2'd0, 8'h00, "R1 data reset");
        rd_reg(2'd1, 8'h00, "R1 dir reset");

        wr_reg(2'd0, 8'hA5);
        rd_reg(2'd0, 8'hA5, "R2 data write");
        wr_reg(2'd1, 8'h0F);
        rd_reg(2'd1, 8'h0F, "R2 dir write");
        rd_reg(2'd3, 8'h00, "R2 unused code");
        check_pads(8'h0F, 8'hA5, 8'hA0, "R7 R8 register pads");

        pu_kill = 1;
        check_pads(8'h0F, 8'hA5, 8'h00, "R9 pull-up kill");
        pu_kill = 0;

        bit_op(2'd1, 3'd6, 1, 0);
        rd_reg(2'd1, 8'h4F, "R4 set dir bit6");
        bit_op(2'd0, 3'd0, 0, 1);
        rd_reg(2'd0, 8'hA4, "R5 clear data bit0");

        wr_reg(2'd2, 8'hFF);
        bit_op(2'd2, 3'd1, 1, 0);
        bit_op(2'd3, 3'd2, 0, 1);
        wr_reg(2'd3, 8'h00);
        rd_reg(2'd0, 8'hA4, "R3 data untouched");
        rd_reg(2'd1, 8'h4F, "R3 dir untouched");

        @(negedge clk); bus_addr = 2'd0; bus_wdata = 8'h00; bus_wr = 1; bus_bset = 1; bus_bidx = 3'd3;
        idle();
        rd_reg(2'd0, 8'h00, "R6 write beats set");
        bit_op(2'd0, 3'd1, 1, 1);
        rd_reg(2'd0, 8'h02, "R6 set beats clear");

        // R10: pad level changes before edge k; reads at k, k+1 give old, k+2 new.
        @(negedge clk); pad_in = 8'h3C; bus_addr = 2'd2; bus_rd = 1;
        exp_q.push_back(8'h00); tag_q.push_back("R10 read at k");
        @(negedge clk); exp_q.push_back(8'h00); tag_q.push_back("R10 read at k+1");
        @(negedge clk); exp_q.push_back(8'h3C); tag_q.push_back("R10 read at k+2");
        @(negedge clk); bus_rd = 0;

        wr_reg(2'd0, 8'h32);
        check_pads(8'h4F, 8'h32, 8'h30, "R8 pull-up mix");
        alt_en = 8'h10; alt_oe = 8'h00; alt_out = 8'h00;
        check_pads(8'h4F, 8'h22, 8'h20, "R11 override on input pin");
        alt_en = 8'h81; alt_oe = 8'h80; alt_out = 8'h81;
        check_pads(8'hCE, 8'hB3, 8'h30, "R11 override two pins");
        alt_en = 8'h00;
        check_pads(8'h4F, 8'h32, 8'h30, "R11 override released");

        repeat (3) @(negedge clk);
        check("R2 scoreboard drained", 8'(exp_q.size()), 8'h00);
        finish_run();
    end
endmodule